// File: doc/BRIEF.md
# Processor Status and Cache Control Register

This block is the status/control word of a small processor core. It keeps four persistent control fields: instruction-cache enable, cache freeze, the global interrupt enable and the external-interrupt trigger mode. It also has a cache-invalidate strobe. Software writes and reads the whole 32-bit word through a plain register port. Writes take effect on the next rising clock edge. Reads are combinational from the stored fields.

Toward the instruction cache, the block produces three signals:
- a read-permission level, which enables hits;
- an update-permission level, which covers both line fills and replacement-order bookkeeping;
- a single-cycle invalidate-all pulse.

Toward the interrupt logic, it exports the interrupt-enable value and the trigger mode. It also accepts a hardware request that forces the interrupt enable low. That request wins over a software write landing in the same cycle.

Top module: `cpu_status_reg`

## Requirements
- R1: While synchronous active-high `rst` is sampled high at a clock edge, every stored field clears. After that edge, `rdData` is 0 and all cache and interrupt outputs are 0.
- R2: A write with `wrEn` high stores the following bits of `wrData` on the next rising edge, and they read back at the same positions: bit 0 (cache enable), bit 1 (freeze), bit 4 (interrupt enable) and bit 5 (trigger mode).
- R3: `cacheRdOk` equals the stored cache-enable bit, whatever the freeze bit holds.
- R4: `cacheUpdOk` is high only when cache enable is 1 and freeze is 0.
- R5: A write with `wrData` bit 2 set makes `cacheInvPulse` high for exactly the one cycle after that edge. This happens whether freeze is 0 or 1, and only once per such write.
- R6: Bit 2 of `rdData` always reads 0.
- R7: Bits 3 and 6 to 31 of `rdData` always read 0, and writing ones to them has no effect.
- R8: When `gieClrReq` is high at an edge, the interrupt enable is 0 after that edge, even if a write of 1 to bit 4 happens in the same cycle.
- R9: Without `wrEn` or `gieClrReq`, all stored fields hold their values.
- R10: `intEdgeMode` and `gieOut` follow the stored trigger-mode and interrupt-enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Write data word |
| gieClrReq | input | 1 | Hardware request to clear interrupt enable |
| rdData | output | 32 | Read data word |
| cacheRdOk | output | 1 | Cache hits permitted |
| cacheUpdOk | output | 1 | Cache fills and replacement updates permitted |
| cacheInvPulse | output | 1 | One-cycle invalidate-all pulse |
| gieOut | output | 1 | Global interrupt enable |
| intEdgeMode | output | 1 | 1 = edge-triggered external interrupts, 0 = level |

## Verification
The bench builds the block with its default parameters: a 32-bit word, with fields at bits 0, 1, 2, 4 and 5. Random full-word writes therefore hit every field and every unused bit. They also cycle through all four enable/freeze combinations, including invalidates issued while frozen. Random hardware interrupt-enable clears, some landing on the same edge as a write of 1, bring the priority rule within reach. Back-to-back invalidate writes show that each write yields one pulse cycle.

// File: rtl/stat_pkg.sv
package stat_pkg;

  localparam int DATA_W_DEF  = 32;
  localparam int EN_POS_DEF  = 0;
  localparam int FRZ_POS_DEF = 1;
  localparam int INV_POS_DEF = 2;
  localparam int GIE_POS_DEF = 4;
  localparam int CFG_POS_DEF = 5;

  // strobes from control to datapath
  typedef struct packed {
    logic loadFields;
    logic fireInvalidate;
    logic forceGieLow;
  } ctlStrobe_t;

  // persistent control fields
  typedef struct packed {
    logic cacheOn;
    logic cacheFrozen;
    logic gieBit;
    logic edgeCfg;
  } fieldSet_t;

endpackage

// File: rtl/stat_ctrl.sv
module stat_ctrl
  import stat_pkg::*;
(
  input  logic       wrEn,
  input  logic       invBit,
  input  logic       gieClrReq,
  output ctlStrobe_t strobe
);

  always_comb begin
    strobe                = '0;
    strobe.loadFields     = wrEn;
    strobe.fireInvalidate = wrEn & invBit;
    strobe.forceGieLow    = gieClrReq;
  end

  // R5: an invalidate strobe only exists with a write
  always_comb begin
    a_r5_inv_needs_write: assert (!strobe.fireInvalidate || wrEn);
  end

endmodule

// File: rtl/stat_datapath.sv
module stat_datapath
  import stat_pkg::*;
#(
  parameter int DATA_W  = DATA_W_DEF,
  parameter int EN_POS  = EN_POS_DEF,
  parameter int FRZ_POS = FRZ_POS_DEF,
  parameter int GIE_POS = GIE_POS_DEF,
  parameter int CFG_POS = CFG_POS_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        strobe,
  input  fieldSet_t         newFields,
  output fieldSet_t         fields,
  output logic              invPulse,
  output logic [DATA_W-1:0] rdData
);

  fieldSet_t fieldsQ;
  logic      invQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      fieldsQ <= '0;
      invQ    <= 1'b0;
    end else begin
      invQ <= strobe.fireInvalidate;
      if (strobe.loadFields) begin
        fieldsQ.cacheOn     <= newFields.cacheOn;
        fieldsQ.cacheFrozen <= newFields.cacheFrozen;
        fieldsQ.edgeCfg     <= newFields.edgeCfg;
      end
      if (strobe.forceGieLow)
        fieldsQ.gieBit <= 1'b0;
      else if (strobe.loadFields)
        fieldsQ.gieBit <= newFields.gieBit;
    end
  end

  assign fields   = fieldsQ;
  assign invPulse = invQ;

  always_comb begin
    rdData          = '0;
    rdData[EN_POS]  = fieldsQ.cacheOn;
    rdData[FRZ_POS] = fieldsQ.cacheFrozen;
    rdData[GIE_POS] = fieldsQ.gieBit;
    rdData[CFG_POS] = fieldsQ.edgeCfg;
  end

  // R8: hardware clear beats a same-cycle write
  a_r8_hw_clear_wins: assert property (@(posedge clk) disable iff (rst)
    strobe.forceGieLow |=> !fields.gieBit);

  // R5: pulse lasts one cycle per invalidate strobe
  a_r5_pulse_source: assert property (@(posedge clk) disable iff (rst)
    invPulse |-> $past(strobe.fireInvalidate));

  // R9: fields hold without a load or a clear
  a_r9_fields_hold: assert property (@(posedge clk) disable iff (rst)
    (!strobe.loadFields && !strobe.forceGieLow) |=> $stable(fields));

endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
  import stat_pkg::*;
#(
  parameter int DATA_W  = DATA_W_DEF,
  parameter int EN_POS  = EN_POS_DEF,
  parameter int FRZ_POS = FRZ_POS_DEF,
  parameter int INV_POS = INV_POS_DEF,
  parameter int GIE_POS = GIE_POS_DEF,
  parameter int CFG_POS = CFG_POS_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              gieClrReq,
  output logic [DATA_W-1:0] rdData,
  output logic              cacheRdOk,
  output logic              cacheUpdOk,
  output logic              cacheInvPulse,
  output logic              gieOut,
  output logic              intEdgeMode
);

  ctlStrobe_t strobe;
  fieldSet_t  newFields;
  fieldSet_t  fields;

  assign newFields.cacheOn     = wrData[EN_POS];
  assign newFields.cacheFrozen = wrData[FRZ_POS];
  assign newFields.gieBit      = wrData[GIE_POS];
  assign newFields.edgeCfg     = wrData[CFG_POS];

  stat_ctrl u_ctrl (
    .wrEn      (wrEn),
    .invBit    (wrData[INV_POS]),
    .gieClrReq (gieClrReq),
    .strobe    (strobe)
  );

  stat_datapath #(
    .DATA_W  (DATA_W),
    .EN_POS  (EN_POS),
    .FRZ_POS (FRZ_POS),
    .GIE_POS (GIE_POS),
    .CFG_POS (CFG_POS)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .newFields (newFields),
    .fields    (fields),
    .invPulse  (cacheInvPulse),
    .rdData    (rdData)
  );

  assign cacheRdOk   = fields.cacheOn;
  assign cacheUpdOk  = fields.cacheOn & ~fields.cacheFrozen;
  assign gieOut      = fields.gieBit;
  assign intEdgeMode = fields.edgeCfg;

  // R4: update permission implies read permission
  a_r4_upd_needs_rd: assert property (@(posedge clk) disable iff (rst)
    cacheUpdOk |-> cacheRdOk);

  // R1: everything is zero after a reset edge
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (rdData == '0 && !cacheInvPulse && !cacheRdOk));

  // R6: strobe bit never reads back
  a_r6_inv_reads_zero: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> !rdData[INV_POS]);

  // R5: a write with the clear bit yields a pulse next cycle
  a_r5_write_pulses: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrData[INV_POS]) |=> cacheInvPulse);

endmodule

// File: tb/tb_cpu_status_reg.sv
module tb_cpu_status_reg;

  logic        clk = 1'b0;
  logic        rst;
  logic        wrEn;
  logic [31:0] wrData;
  logic        gieClrReq;
  logic [31:0] rdData;
  logic        cacheRdOk, cacheUpdOk, cacheInvPulse, gieOut, intEdgeMode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic mEn = 0, mFrz = 0, mGie = 0, mCfg = 0, mPulse = 0;

  always #4 clk = ~clk;

  cpu_status_reg dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .gieClrReq(gieClrReq),
    .rdData(rdData), .cacheRdOk(cacheRdOk), .cacheUpdOk(cacheUpdOk),
    .cacheInvPulse(cacheInvPulse), .gieOut(gieOut), .intEdgeMode(intEdgeMode)
  );

  function automatic logic [31:0] expWord(logic e, logic f, logic g, logic c);
    logic [31:0] w;
    w = '0;
    w[0] = e; w[1] = f; w[4] = g; w[5] = c;
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkAll();
    chk("R2/R6/R7 rdData", rdData, expWord(mEn, mFrz, mGie, mCfg));
    chk("R3 cacheRdOk", {31'b0, cacheRdOk}, {31'b0, mEn});
    chk("R4 cacheUpdOk", {31'b0, cacheUpdOk}, {31'b0, mEn & ~mFrz});
    chk("R5 cacheInvPulse", {31'b0, cacheInvPulse}, {31'b0, mPulse});
    chk("R10 gieOut", {31'b0, gieOut}, {31'b0, mGie});
    chk("R10 intEdgeMode", {31'b0, intEdgeMode}, {31'b0, mCfg});
  endtask

  // drive at negedge, advance one edge, check at next negedge
  task automatic step(logic r, logic w, logic [31:0] d, logic hc);
    rst = r; wrEn = w; wrData = d; gieClrReq = hc;
    if (r) begin
      mEn = 0; mFrz = 0; mGie = 0; mCfg = 0; mPulse = 0;
    end else begin
      mPulse = w & d[2];
      if (w) begin mEn = d[0]; mFrz = d[1]; mCfg = d[5]; end
      if (hc) mGie = 0;
      else if (w) mGie = d[4];
    end
    @(posedge clk);
    @(negedge clk);
    checkAll();
  endtask

  initial begin
    process::self().srandom(32'd1234);
    rst = 1; wrEn = 0; wrData = '0; gieClrReq = 0;
    @(negedge clk);
    // R1: reset state
    step(1, 0, '0, 0);
    step(1, 1, 32'hFFFF_FFFF, 0);
    chk("R1 reset rdData", rdData, 32'h0);
    // R2/R7: all ones written, unused bits stay 0
    step(0, 1, 32'hFFFF_FFFF, 0);
    chk("R7 unused bits zero", rdData & ~32'h33, 32'h0);
    // R5: pulse only once, the next cycle idle
    step(0, 0, 32'h0, 0);
    chk("R5 pulse single cycle", {31'b0, cacheInvPulse}, 32'h0);
    // R5: clear while frozen
    step(0, 1, 32'h0000_0007, 0);
    chk("R5 pulse while frozen", {31'b0, cacheInvPulse}, 32'h1);
    chk("R4 frozen blocks update", {31'b0, cacheUpdOk}, 32'h0);
    // R5: back-to-back clears
    step(0, 1, 32'h0000_0005, 0);
    step(0, 1, 32'h0000_0005, 0);
    chk("R5 back-to-back pulse", {31'b0, cacheInvPulse}, 32'h1);
    // R8: hw clear vs write of 1
    step(0, 1, 32'h0000_0010, 0);
    step(0, 1, 32'h0000_0010, 1);
    chk("R8 hw clear wins", {31'b0, gieOut}, 32'h0);
    // R9: idle holds
    step(0, 1, 32'h0000_0031, 0);
    step(0, 0, 32'hFFFF_FFFF, 0);
    chk("R9 hold", rdData, 32'h31);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic r, w, hc;
      logic [31:0] d;
      r  = ($urandom % 50) == 0;
      w  = ($urandom % 3) != 0;
      hc = ($urandom % 6) == 0;
      d  = $urandom;
      step(r, w, d, hc);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule